// File: doc/BRIEF.md
# Keyed-Command Watchdog Timer

This block is a watchdog timer on a small word-addressed register bus. Software keeps it from firing by writing a refresh key to its command register before the counter reaches a programmed limit. If the limit is reached, the block raises a sticky interrupt flag and drives a fixed-length reset pulse. Changes to its configuration (enable, tick source, limit, refresh window) are accepted only during a short unlocked period, which a separate unlock key opens.

Keys reach the block in one of two forms, chosen by a control bit. In the wide form, a single 32-bit write carries the whole key. In the narrow form, the key is split into two 16-bit halves that must arrive as consecutive writes to the command register. Status bits show whether the block is unlocked and whether the last reconfiguration has been taken. A refresh window can be set so that a refresh arriving too early is treated as a fault.

Top module: `keyed_wdog`

## Requirements
- R1: Word addresses are 0 = control, 1 = command (a read returns the counter value), 2 = limit and 3 = window. After reset, the control register reads 0x2420 (bits 5, 10 and 13 set), the limit reads 0xFFFF, the window and the counter read 0, and `wdog_rst` and `wdog_irq` are low.
- R2: While control bit 13 is 1, a command write of 0xD928C520 unlocks the block and a command write of 0xB480A602 refreshes it. While bit 13 is 0, neither 32-bit word has any effect.
- R3: While control bit 13 is 0, a command write of 0x0000C520 followed by 0x0000D928 unlocks the block, and 0x0000A602 followed by 0x0000B480 refreshes it. Both words of a pair must be consecutive command writes. If the second write is not the expected word, it is discarded and the block waits again for a first word.
- R4: Writes to the control, limit and window registers take effect only while the unlocked bit (control bit 11) reads 1. At any other time they change nothing.
- R5: An accepted unlock sets bit 11 for exactly 255 clock cycles and clears bit 10. A control write made while unlocked ends the unlocked period at once and sets bit 10.
- R6: If an accepted control write leaves bit 5 at 0, every later unlock key is ignored until reset.
- R7: While control bit 7 is 1, the counter increments on each clock in which the `tick_src` line selected by control bits 9:8 is high. While bit 7 is 0, it holds. An accepted control write clears the counter.
- R8: A counted tick that would bring the counter to a value greater than or equal to the limit instead clears the counter, sets the flag (control bit 14) and drives `wdog_rst` high for exactly 16 cycles.
- R9: `wdog_irq` follows the flag. An accepted control write with bit 14 set clears the flag. A write while locked does not.
- R10: A refresh clears the counter. If the counter is enabled, the window is nonzero and the counter is below the window when the refresh arrives, a 16-cycle `wdog_rst` pulse is issued, and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_src | input | 4 | Candidate tick strobes, one selected by control bits 9:8 |
| wdog_rst | output | 1 | Reset pulse on timeout or window violation |
| wdog_irq | output | 1 | Timeout interrupt, equal to the sticky flag |

## Verification
The assertions take for granted that the bus carries at most one write per clock and that the command, control and limit registers are never written in the same cycle. They also assume that tick strobes come from the same clock domain, so a counted tick is a one-cycle condition. The stimulus drives every write and tick for exactly one cycle, starting from the falling edge. Between configurations it waits for any reset pulse to end, so each sweep point starts from a cleared counter and a cleared flag.

// File: rtl/keyed_wdog_pkg.sv
// Shared constants for the keyed watchdog: register word addresses,
// control-register bit positions and the command key values.
package keyed_wdog_pkg;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_CMD   = 2'd1;
    localparam logic [1:0] ADDR_LIMIT = 2'd2;
    localparam logic [1:0] ADDR_WIN   = 2'd3;

    localparam int B_UPD = 5;
    localparam int B_EN  = 7;
    localparam int B_SEL = 8;
    localparam int B_RCS = 10;
    localparam int B_ULK = 11;
    localparam int B_C32 = 13;
    localparam int B_FLG = 14;

    localparam logic [31:0] KEY_UNLK32 = 32'hD928_C520;
    localparam logic [31:0] KEY_REF32  = 32'hB480_A602;
    localparam logic [31:0] KEY_UNLK_A = 32'h0000_C520;
    localparam logic [31:0] KEY_UNLK_B = 32'h0000_D928;
    localparam logic [31:0] KEY_REF_A  = 32'h0000_A602;
    localparam logic [31:0] KEY_REF_B  = 32'h0000_B480;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_UNLK = 2'd1,
        SEQ_REF  = 2'd2
    } seq_e;

endpackage

// File: rtl/keyed_wdog_cmd.sv
// Command-key decoder. Turns writes to the command register into one-cycle
// unlock and refresh requests. In wide mode each write is matched on its own.
// In narrow mode a first half arms a pending state, and the next command
// write either completes the pair or aborts it.
// Assumes: cmd_wr is high for one cycle per bus write.
module keyed_wdog_cmd
    import keyed_wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        mode32,
    input  logic [31:0] wdata,
    output logic        unlock_o,
    output logic        refresh_o
);

    seq_e st_q, st_d;

    // Key matching and next state of the narrow-pair sequencer.
    always_comb begin
        st_d      = st_q;
        unlock_o  = 1'b0;
        refresh_o = 1'b0;
        if (cmd_wr) begin
            if (mode32) begin
                st_d      = SEQ_IDLE;
                unlock_o  = (wdata == KEY_UNLK32);
                refresh_o = (wdata == KEY_REF32);
            end else begin
                case (st_q)
                    SEQ_UNLK: begin
                        st_d     = SEQ_IDLE;
                        unlock_o = (wdata == KEY_UNLK_B);
                    end
                    SEQ_REF: begin
                        st_d      = SEQ_IDLE;
                        refresh_o = (wdata == KEY_REF_B);
                    end
                    default: begin
                        if (wdata == KEY_UNLK_A)
                            st_d = SEQ_UNLK;
                        else if (wdata == KEY_REF_A)
                            st_d = SEQ_REF;
                    end
                endcase
            end
        end
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= SEQ_IDLE;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/keyed_wdog_cfg.sv
// Configuration store with unlock gating. Holds the control fields, limit
// and window. An unlock opens a write window of UNLOCK_CYC cycles, and a
// control write closes it early. If update permission is cleared, further
// unlocks are refused until reset. Also holds the sticky timeout flag.
// Assumes: unlock_req and timeout_ev are one-cycle strobes.
module keyed_wdog_cfg
    import keyed_wdog_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int UNLOCK_CYC = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      wdata,
    input  logic             unlock_req,
    input  logic             timeout_ev,
    output logic             en,
    output logic             upd,
    output logic [1:0]       sel,
    output logic             mode32,
    output logic             rcs,
    output logic             ulk,
    output logic             flag,
    output logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] win,
    output logic             ctrl_wr
);

    localparam int UW = $clog2(UNLOCK_CYC + 1);

    logic [UW-1:0] ucnt_q;
    logic          wr_ok;
    logic          unlock_ok;
    logic          unused_bits;

    assign ulk         = (ucnt_q != '0);
    assign wr_ok       = bus_wr && ulk;
    assign ctrl_wr     = wr_ok && (bus_addr == ADDR_CTRL);
    assign unlock_ok   = unlock_req && upd;
    assign unused_bits = ^{wdata[31:15], wdata[12:10], wdata[6], wdata[4:0]};

    // Unlock window down-counter: loaded on unlock, cleared by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ucnt_q <= '0;
        else if (ctrl_wr)
            ucnt_q <= '0;
        else if (unlock_ok)
            ucnt_q <= UW'(UNLOCK_CYC);
        else if (ulk)
            ucnt_q <= ucnt_q - 1'b1;
    end

    // Control fields and the reconfiguration-done status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            upd    <= 1'b1;
            sel    <= 2'd0;
            mode32 <= 1'b1;
            rcs    <= 1'b1;
        end else if (ctrl_wr) begin
            en     <= wdata[B_EN];
            upd    <= wdata[B_UPD];
            sel    <= wdata[B_SEL+1:B_SEL];
            mode32 <= wdata[B_C32];
            rcs    <= 1'b1;
        end else if (unlock_ok) begin
            rcs    <= 1'b0;
        end
    end

    // Sticky timeout flag: a new timeout wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (timeout_ev)
            flag <= 1'b1;
        else if (ctrl_wr && wdata[B_FLG])
            flag <= 1'b0;
    end

    // Limit and window registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit <= '1;
            win   <= '0;
        end else if (wr_ok) begin
            if (bus_addr == ADDR_LIMIT)
                limit <= wdata[CNT_W-1:0];
            if (bus_addr == ADDR_WIN)
                win <= wdata[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/keyed_wdog_cnt.sv
// Timeout counter and reset-pulse generator. Counts qualified ticks, fires
// when the next count would reach the limit, checks refreshes against the
// window, and stretches either event into an RST_CYC-cycle reset pulse.
// Assumes: clear and refresh are never high in the same cycle.
module keyed_wdog_cnt #(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             clear,
    input  logic             refresh,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] win,
    output logic [CNT_W-1:0] cnt_q,
    output logic             timeout_ev,
    output logic             viol_ev,
    output logic             rst_o
);

    localparam int RW = $clog2(RST_CYC + 1);

    logic [CNT_W:0]  cnt_next;
    logic [RW-1:0]   pulse_q;

    assign cnt_next   = {1'b0, cnt_q} + 1'b1;
    assign timeout_ev = tick && !clear && !refresh && (cnt_next >= {1'b0, limit});
    assign viol_ev    = refresh && en && (win != '0) && (cnt_q < win);
    assign rst_o      = (pulse_q != '0);

    // Counter: clear and refresh take priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || refresh || timeout_ev)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_next[CNT_W-1:0];
    end

    // Reset pulse length counter, restarted by any new event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= '0;
        else if (timeout_ev || viol_ev)
            pulse_q <= RW'(RST_CYC);
        else if (rst_o)
            pulse_q <= pulse_q - 1'b1;
    end

endmodule

// File: rtl/keyed_wdog.sv
// Keyed-command watchdog top. Wires the key decoder, configuration store
// and counter together, selects the tick source, and returns register reads.
// Assumes: one bus write per cycle; tick_src is synchronous to clk.
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int UNLOCK_CYC = 255,
    parameter int RST_CYC    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [3:0]  tick_src,
    output logic        wdog_rst,
    output logic        wdog_irq
);

    logic             unlock_req, refresh_req;
    logic             en, upd, mode32, rcs, ulk, flag, ctrl_wr;
    logic [1:0]       sel;
    logic [CNT_W-1:0] limit, win, cnt_val;
    logic             cnt_tick, timeout_ev, viol_ev;
    logic             cmd_wr;

    assign cmd_wr   = bus_wr && (bus_addr == ADDR_CMD);
    assign cnt_tick = en && tick_src[sel];
    assign wdog_irq = flag;

    keyed_wdog_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .mode32    (mode32),
        .wdata     (bus_wdata),
        .unlock_o  (unlock_req),
        .refresh_o (refresh_req)
    );

    keyed_wdog_cfg #(.CNT_W(CNT_W), .UNLOCK_CYC(UNLOCK_CYC)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .wdata      (bus_wdata),
        .unlock_req (unlock_req),
        .timeout_ev (timeout_ev),
        .en         (en),
        .upd        (upd),
        .sel        (sel),
        .mode32     (mode32),
        .rcs        (rcs),
        .ulk        (ulk),
        .flag       (flag),
        .limit      (limit),
        .win        (win),
        .ctrl_wr    (ctrl_wr)
    );

    keyed_wdog_cnt #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (cnt_tick),
        .en         (en),
        .clear      (ctrl_wr),
        .refresh    (refresh_req),
        .limit      (limit),
        .win        (win),
        .cnt_q      (cnt_val),
        .timeout_ev (timeout_ev),
        .viol_ev    (viol_ev),
        .rst_o      (wdog_rst)
    );

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[B_UPD]           = upd;
                bus_rdata[B_EN]            = en;
                bus_rdata[B_SEL+1:B_SEL]   = sel;
                bus_rdata[B_RCS]           = rcs;
                bus_rdata[B_ULK]           = ulk;
                bus_rdata[B_C32]           = mode32;
                bus_rdata[B_FLG]           = flag;
            end
            ADDR_CMD:   bus_rdata = 32'(cnt_val);
            ADDR_LIMIT: bus_rdata = 32'(limit);
            default:    bus_rdata = 32'(win);
        endcase
    end

endmodule

// File: rtl/keyed_wdog_chk.sv
// Assertion checker for keyed_wdog, attached by bind. Watches the internal
// strobes and registers and checks the timing rules of the requirements.
// Pulse and window lengths are checked with local run counters.
module keyed_wdog_chk #(
    parameter int CNT_W      = 16,
    parameter int UNLOCK_CYC = 255,
    parameter int RST_CYC    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             unlock_req,
    input logic             refresh_req,
    input logic             ulk,
    input logic             upd,
    input logic             ctrl_wr,
    input logic             cnt_tick,
    input logic             timeout_ev,
    input logic             viol_ev,
    input logic             wdog_rst,
    input logic             wdog_irq,
    input logic [CNT_W-1:0] limit,
    input logic [CNT_W-1:0] cnt_val
);

    localparam int UW = $clog2(UNLOCK_CYC + 1);
    localparam int RW = $clog2(RST_CYC + 1);

    logic [UW-1:0] ulk_run;
    logic [RW-1:0] rst_run;

    // Cycles the unlocked state has lasted since the last unlock key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ulk_run <= '0;
        else if (unlock_req || !ulk)
            ulk_run <= '0;
        else
            ulk_run <= ulk_run + 1'b1;
    end

    // Cycles the reset pulse has lasted since its last trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_run <= '0;
        else if (timeout_ev || viol_ev || !wdog_rst)
            rst_run <= '0;
        else
            rst_run <= rst_run + 1'b1;
    end

    a_r5_unlock_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ulk |-> (ulk_run < UW'(UNLOCK_CYC)));

    a_r8_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> (rst_run < RW'(RST_CYC)));

    a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_ev || viol_ev) |=> wdog_rst);

    a_r8_timeout_effect: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_ev |=> (wdog_irq && cnt_val == '0));

    a_r6_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && unlock_req) |=> !ulk);

    a_r4_locked_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !ulk) |=> $stable(limit));

    a_r10_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> (cnt_val == '0));

    a_r7_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !refresh_req && !ctrl_wr) |=> $stable(cnt_val));

endmodule

bind keyed_wdog keyed_wdog_chk #(
    .CNT_W(CNT_W), .UNLOCK_CYC(UNLOCK_CYC), .RST_CYC(RST_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .unlock_req  (unlock_req),
    .refresh_req (refresh_req),
    .ulk         (ulk),
    .upd         (upd),
    .ctrl_wr     (ctrl_wr),
    .cnt_tick    (cnt_tick),
    .timeout_ev  (timeout_ev),
    .viol_ev     (viol_ev),
    .wdog_rst    (wdog_rst),
    .wdog_irq    (wdog_irq),
    .limit       (limit),
    .cnt_val     (cnt_val)
);

// File: tb/keyed_wdog_bench.sv
// Self-checking bench: sweeps limits and window/refresh positions, and
// walks through both key forms, the unlock window, lockout and tick selection.
module keyed_wdog_bench;

    localparam logic [31:0] UPD = 32'h0000_0020;
    localparam logic [31:0] EN  = 32'h0000_0080;
    localparam logic [31:0] RCS = 32'h0000_0400;
    localparam logic [31:0] ULK = 32'h0000_0800;
    localparam logic [31:0] C32 = 32'h0000_2000;
    localparam logic [31:0] FLG = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_src = '0;
    logic        wdog_rst, wdog_irq;

    int total = 0;
    int fails = 0;
    logic done = 1'b0;

    keyed_wdog u_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src),
        .wdog_rst(wdog_rst), .wdog_irq(wdog_irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int src);
        @(negedge clk);
        tick_src = 4'(1 << src);
        @(negedge clk);
        tick_src = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick(0);
    endtask

    // Unlock in wide form, program limit and window, then write control.
    task automatic setup(input logic [31:0] lim, input logic [31:0] w, input logic [31:0] ctrl);
        wr(2'd1, 32'hD928_C520);
        wr(2'd2, lim);
        wr(2'd3, w);
        wr(2'd0, ctrl | FLG);
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (wdog_rst && n < 40) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 32'h0000_2420);
        rd(2'd2, d); check("R1 limit", d, 32'h0000_FFFF);
        rd(2'd3, d); check("R1 window", d, 0);
        rd(2'd1, d); check("R1 count", d, 0);
        check("R1 rst/irq", {30'd0, wdog_rst, wdog_irq}, 0);

        // R4 locked writes ignored
        wr(2'd2, 32'h1234);
        rd(2'd2, d); check("R4 locked limit", d, 32'h0000_FFFF);

        // R5 unlock window length and status bits
        wr(2'd1, 32'hD928_C520);
        rd(2'd0, d); check("R5 ulk set rcs clear", d & (ULK | RCS), ULK);
        repeat (254) @(negedge clk);
        rd(2'd0, d); check("R5 ulk at cycle 255", d & ULK, ULK);
        @(negedge clk);
        rd(2'd0, d); check("R5 ulk expired", d & ULK, 0);
        wr(2'd2, 32'h0055);
        rd(2'd2, d); check("R4 limit after expiry", d, 32'h0000_FFFF);

        // R5 control write ends unlock; R4 unlocked writes accepted
        setup(32'd7, 32'd3, UPD | C32);
        rd(2'd0, d); check("R5 ctrl write relocks", d & (ULK | RCS), RCS);
        rd(2'd2, d); check("R4 limit written", d, 7);
        rd(2'd3, d); check("R4 window written", d, 3);

        // R8 limit sweep
        for (int lim = 1; lim <= 5; lim++) begin
            setup(32'(lim), 32'd0, EN | UPD | C32);
            ticks(lim - 1);
            rd(2'd1, d); check("R8 count before limit", d, 32'(lim - 1));
            check("R8 no reset before limit", {31'd0, wdog_rst}, 0);
            tick(0);
            check("R8 reset at limit", {30'd0, wdog_rst, wdog_irq}, 3);
            rd(2'd1, d); check("R8 count cleared", d, 0);
            pulse_len(n); check("R8 pulse length", 32'(n), 16);
        end

        // R9 flag clear only while unlocked
        wr(2'd0, EN | UPD | C32 | FLG);
        check("R9 locked clear ignored", {31'd0, wdog_irq}, 1);
        rd(2'd0, d); check("R9 flag bit", d & FLG, FLG);
        setup(32'd20, 32'd0, EN | UPD | C32);
        check("R9 flag cleared", {31'd0, wdog_irq}, 0);

        // R10 window sweep: refresh after c ticks with window w
        for (int w = 1; w <= 3; w++) begin
            for (int c = 0; c <= 4; c++) begin
                setup(32'd20, 32'(w), EN | UPD | C32);
                ticks(c);
                wr(2'd1, 32'hB480_A602);
                check($sformatf("R10 violation w=%0d c=%0d", w, c),
                      {31'd0, wdog_rst}, {31'd0, (c < w)});
                rd(2'd1, d); check("R10 refresh clears", d, 0);
                check("R10 no flag", {31'd0, wdog_irq}, 0);
                repeat (18) @(negedge clk);
            end
        end

        // R3/R2 narrow mode
        setup(32'd20, 32'd0, EN | UPD);
        wr(2'd1, 32'hD928_C520);
        rd(2'd0, d); check("R2 wide unlock ignored in narrow", d & ULK, 0);
        ticks(3);
        wr(2'd1, 32'hB480_A602);
        rd(2'd1, d); check("R2 wide refresh ignored in narrow", d, 3);
        wr(2'd1, 32'h0000_A602); wr(2'd1, 32'h0000_B480);
        rd(2'd1, d); check("R3 narrow refresh", d, 0);
        ticks(2);
        wr(2'd1, 32'h0000_A602); wr(2'd1, 32'h0000_1234); wr(2'd1, 32'h0000_B480);
        rd(2'd1, d); check("R3 aborted refresh", d, 2);
        wr(2'd1, 32'h0000_C520); wr(2'd1, 32'h0000_0000); wr(2'd1, 32'h0000_D928);
        rd(2'd0, d); check("R3 aborted unlock", d & ULK, 0);
        wr(2'd1, 32'h0000_C520); wr(2'd1, 32'h0000_D928);
        rd(2'd0, d); check("R3 narrow unlock", d & ULK, ULK);
        wr(2'd0, UPD | C32 | FLG);
        rd(2'd0, d); check("R2 back to wide", d & C32, C32);

        // R7 tick select and enable
        setup(32'd20, 32'd0, EN | UPD | C32 | 32'h100);
        tick(0);
        rd(2'd1, d); check("R7 unselected tick ignored", d, 0);
        tick(1); tick(1);
        rd(2'd1, d); check("R7 selected tick counts", d, 2);
        setup(32'd20, 32'd0, UPD | C32);
        rd(2'd1, d); check("R7 ctrl write clears", d, 0);
        ticks(3);
        rd(2'd1, d); check("R7 disabled holds", d, 0);

        // R6 lockout
        setup(32'd9, 32'd0, C32);
        wr(2'd1, 32'hD928_C520);
        rd(2'd0, d); check("R6 unlock refused", d & ULK, 0);
        wr(2'd2, 32'd5);
        rd(2'd2, d); check("R6 limit unchanged", d, 9);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule